// File: doc/BRIEF.md
# FIFO Flag Threshold Loader

This block owns the two threshold values that a synchronous FIFO compares against its fill level. The low threshold (X) drives the almost-empty flag and the high threshold (Y) drives the almost-full flag. When reset is released, two select pins choose how the thresholds get their values. There are two fixed presets. A third mode takes both values from the first two writes on the FIFO write port. A fourth mode shifts both values in one bit at a time through the two select pins.

Until the thresholds are usable, the block keeps the FIFO's write-ready flag low. In the write-port mode it also tells the FIFO which accepted writes are threshold writes and which ones go to memory. After that it flags ordinary data writes. Clock and reset are the FIFO's write-side clock and its active-low reset.

Top module: `ofs_loader`

## Requirements
- R1: The mode is taken from `{sel_hi, sel_lo}` on the first rising clock edge after `rst_n` goes high. The codes are 2'b11 serial, 2'b10 preset 64, 2'b01 preset 8 and 2'b00 write-port load. Later changes on the select pins do not change the mode.
- R2: While `rst_n` is low, `ready`, `done`, `ofs_wr` and `mem_wr` are low and both thresholds read 0.
- R3: In a preset mode, `ofs_x` and `ofs_y` both equal the preset. `ready` and `done` rise on the second rising edge after reset release.
- R4: In write-port mode, `ready` rises on the second rising edge after release. `done` stays low until two threshold writes have been accepted.
- R5: In write-port mode, the first accepted write with `ready` high loads `ofs_y` from `wr_data` (bit W-1 is the MSB). The second loads `ofs_x`. Both assert `ofs_wr` and keep `mem_wr` low.
- R6: A write is qualified only when `wr_en`=1, `cs_n`=0 and `wr_dir`=1. An unqualified write asserts neither strobe and loads nothing.
- R7: Once `done` is high, a qualified write asserts `mem_wr` and not `ofs_wr`, and the thresholds keep their values.
- R8: In serial mode, starting with the second edge after release, each rising edge with `sel_hi` low shifts in `sel_lo`. The first bit is the MSB of Y and the last is the LSB of X. Edges with `sel_hi` high shift nothing.
- R9: In serial mode, `ready` and `done` rise on the edge after the 2*W-th bit. Any further serial bits are ignored.
- R10: While `ready` is low, a qualified write asserts neither `ofs_wr` nor `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_hi | input | 1 | Mode select high bit; serial enable (active low) after release |
| sel_lo | input | 1 | Mode select low bit; serial data after release |
| wr_en | input | 1 | Write enable |
| cs_n | input | 1 | Chip select, active low |
| wr_dir | input | 1 | 1 selects the write direction |
| wr_data | input | W | Low bits of the FIFO write data bus |
| ofs_x | output | W | Almost-empty threshold |
| ofs_y | output | W | Almost-full threshold |
| ready | output | 1 | FIFO write-ready flag |
| done | output | 1 | Thresholds are final |
| ofs_wr | output | 1 | Current write is a threshold write, not stored |
| mem_wr | output | 1 | Current write is a data write |

## Verification
The bench targets the edge that latches the mode. A design that samples the selects one cycle late would pick up serial data as a mode, or would let a preset change after release. It counts the two-edge ready delay and the one-edge delay after the final serial bit. An off-by-one counter would raise `ready` early, or accept a 19th bit and shift X. The bench also interleaves unqualified and early writes in write-port mode. A loader that counted those, or that swapped the Y/X order, would show wrong thresholds or a stray `ofs_wr` or `mem_wr`.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

   // Encoding is {sel_hi, sel_lo} sampled at the first edge after reset release
   typedef enum logic [1:0] {
      LM_PORT   = 2'b00,
      LM_SMALL  = 2'b01,
      LM_LARGE  = 2'b10,
      LM_SERIAL = 2'b11
   } load_mode_t;

endpackage

// File: rtl/ofs_mode_ctl.sv
module ofs_mode_ctl
   import ofs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_hi,
   input  logic       sel_lo,
   output load_mode_t mode,
   output logic       mode_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= LM_PORT;
         mode_valid <= 1'b0;
      end else if (!mode_valid) begin
         mode       <= load_mode_t'({sel_hi, sel_lo});
         mode_valid <= 1'b1;
      end
   end

endmodule

// File: rtl/ofs_serial_chain.sv
module ofs_serial_chain #(
   parameter int W = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           arm,
   input  logic           sen_n,
   input  logic           sd,
   output logic [2*W-1:0] chain,
   output logic           full
);

   localparam int CHAIN = 2 * W;
   localparam int CW    = $clog2(CHAIN + 1);

   logic [CW-1:0] cnt;
   logic          step;

   assign full = (cnt == CW'(CHAIN));
   assign step = arm && !sen_n && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         cnt   <= '0;
      end else if (step) begin
         chain <= {chain[CHAIN-2:0], sd};
         cnt   <= cnt + CW'(1);
      end
   end

endmodule

// File: rtl/ofs_port_loader.sv
module ofs_port_loader #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] ofs_y,
   output logic [W-1:0] ofs_x,
   output logic         both
);

   localparam int NREG = 2;

   logic [1:0]   cnt;
   logic [W-1:0] regs [NREG];

   assign both  = (cnt == 2'(NREG));
   assign ofs_y = regs[0];
   assign ofs_x = regs[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load && !both) cnt <= cnt + 2'd1;
   end

   // Slot 0 is Y, slot 1 is X: write order is fixed by the FIFO's protocol
   for (genvar g = 0; g < NREG; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     regs[g] <= '0;
         else if (load && cnt == 2'(g))  regs[g] <= din;
      end
   end

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
   import ofs_pkg::*;
#(
   parameter int DEPTH        = 512,
   parameter int PRESET_SMALL = 8,
   parameter int PRESET_LARGE = 64,
   localparam int W           = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel_hi,
   input  logic         sel_lo,
   input  logic         wr_en,
   input  logic         cs_n,
   input  logic         wr_dir,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] ofs_x,
   output logic [W-1:0] ofs_y,
   output logic         ready,
   output logic         done,
   output logic         ofs_wr,
   output logic         mem_wr
);

   localparam int           MAX_OFS = DEPTH - 4;
   localparam logic [W-1:0] SMALL_V = W'(PRESET_SMALL);
   localparam logic [W-1:0] LARGE_V = W'(PRESET_LARGE);

   if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ofs_loader: DEPTH must be a power of two of at least 16");
   end
   if (PRESET_SMALL < 1 || PRESET_SMALL > MAX_OFS) begin : g_bad_small
      $error("ofs_loader: PRESET_SMALL out of 1..DEPTH-4");
   end
   if (PRESET_LARGE < 1 || PRESET_LARGE > MAX_OFS) begin : g_bad_large
      $error("ofs_loader: PRESET_LARGE out of 1..DEPTH-4");
   end

   load_mode_t     mode;
   logic           mode_valid;
   logic [2*W-1:0] chain;
   logic           chain_full;
   logic [W-1:0]   port_y, port_x;
   logic           port_both;
   logic           ready_q;
   logic           qual;
   logic           is_port, is_serial;

   ofs_mode_ctl i_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_hi     (sel_hi),
      .sel_lo     (sel_lo),
      .mode       (mode),
      .mode_valid (mode_valid)
   );

   assign is_port   = mode_valid && (mode == LM_PORT);
   assign is_serial = mode_valid && (mode == LM_SERIAL);

   ofs_serial_chain #(.W(W)) i_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (is_serial),
      .sen_n (sel_hi),
      .sd    (sel_lo),
      .chain (chain),
      .full  (chain_full)
   );

   ofs_port_loader #(.W(W)) i_port (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ofs_wr),
      .din   (wr_data),
      .ofs_y (port_y),
      .ofs_x (port_x),
      .both  (port_both)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ready_q <= 1'b0;
      else if (!mode_valid) ready_q <= 1'b0;
      else if (is_serial)  ready_q <= chain_full;
      else                 ready_q <= 1'b1;
   end

   assign qual   = wr_en && !cs_n && wr_dir;
   assign ready  = ready_q;
   assign done   = ready_q && (!is_port || port_both);
   assign ofs_wr = qual && ready_q && is_port && !port_both;
   assign mem_wr = qual && done;

   always_comb begin
      ofs_x = '0;
      ofs_y = '0;
      if (mode_valid) begin
         unique case (mode)
            LM_SMALL:  begin ofs_x = SMALL_V;        ofs_y = SMALL_V;          end
            LM_LARGE:  begin ofs_x = LARGE_V;        ofs_y = LARGE_V;          end
            LM_PORT:   begin ofs_x = port_x;         ofs_y = port_y;           end
            LM_SERIAL: begin ofs_x = chain[W-1:0];   ofs_y = chain[2*W-1:W];   end
            default:   begin ofs_x = '0;             ofs_y = '0;               end
         endcase
      end
   end

endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
   parameter int W = 9
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic         cs_n,
   input logic         wr_dir,
   input logic [W-1:0] ofs_x,
   input logic [W-1:0] ofs_y,
   input logic         ready,
   input logic         done,
   input logic         ofs_wr,
   input logic         mem_wr
);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R2: assert (!ready && !done && !ofs_wr && !mem_wr)
            else $error("R2: outputs active during reset");
      end
   end

   assert_ofs_wr_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_wr |-> (wr_en && !cs_n && wr_dir));

   assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(ofs_wr && mem_wr));

   assert_mem_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> done);

   assert_done_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);

   assert_no_strobe_unready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (!ofs_wr && !mem_wr));

   assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   assert_offsets_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> ($stable(ofs_x) && $stable(ofs_y)));

endmodule

bind ofs_loader ofs_loader_chk #(.W(W)) i_ofs_loader_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .cs_n   (cs_n),
   .wr_dir (wr_dir),
   .ofs_x  (ofs_x),
   .ofs_y  (ofs_y),
   .ready  (ready),
   .done   (done),
   .ofs_wr (ofs_wr),
   .mem_wr (mem_wr)
);

// File: tb/test_ofs_loader.sv
module test_ofs_loader;

   localparam int  DEPTH      = 512;
   localparam int  W          = $clog2(DEPTH);
   localparam int  NB         = 2 * W;
   localparam time CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sel_hi = 1'b0, sel_lo = 1'b0;
   logic         wr_en = 1'b0, cs_n = 1'b1, wr_dir = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] ofs_x, ofs_y;
   logic         ready, done, ofs_wr, mem_wr;

   always #(CLK_PERIOD/2) clk = ~clk;

   ofs_loader #(.DEPTH(DEPTH)) i_ofs_loader (
      .clk(clk), .rst_n(rst_n), .sel_hi(sel_hi), .sel_lo(sel_lo),
      .wr_en(wr_en), .cs_n(cs_n), .wr_dir(wr_dir), .wr_data(wr_data),
      .ofs_x(ofs_x), .ofs_y(ofs_y), .ready(ready), .done(done),
      .ofs_wr(ofs_wr), .mem_wr(mem_wr)
   );

   int    n_vec = 0, n_bad = 0;
   string req = "R2";

   // Reference model state
   bit m_valid;
   int m_mode;
   bit m_ready;
   bit m_bits[$];
   int m_pcnt, m_px, m_py;

   function automatic void m_reset();
      m_valid = 0; m_mode = 0; m_ready = 0;
      m_bits.delete(); m_pcnt = 0; m_px = 0; m_py = 0;
   endfunction

   task automatic chk(string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(bit en, bit csn, bit dir, int d, bit shi, bit slo);
      int  ex, ey, v;
      bit  qual, edone, eofs, emem;
      wr_en = en; cs_n = csn; wr_dir = dir; wr_data = W'(d);
      sel_hi = shi; sel_lo = slo;
      #1;
      ex = 0; ey = 0;
      if (m_valid) begin
         case (m_mode)
            1: begin ex = 8;    ey = 8;    end
            2: begin ex = 64;   ey = 64;   end
            0: begin ex = m_px; ey = m_py; end
            default: begin
               v = 0;
               foreach (m_bits[i]) v = ((v << 1) | int'(m_bits[i])) & ((1 << NB) - 1);
               ey = v >> W;
               ex = v & ((1 << W) - 1);
            end
         endcase
      end
      qual  = en && !csn && dir;
      edone = m_ready && (m_mode != 0 || m_pcnt == 2);
      eofs  = qual && m_ready && m_valid && m_mode == 0 && m_pcnt < 2;
      emem  = qual && edone;
      chk("ready",  int'(ready),  int'(m_ready));
      chk("done",   int'(done),   int'(edone));
      chk("ofs_wr", int'(ofs_wr), int'(eofs));
      chk("mem_wr", int'(mem_wr), int'(emem));
      chk("ofs_x",  int'(ofs_x),  ex);
      chk("ofs_y",  int'(ofs_y),  ey);
      @(posedge clk);
      if (rst_n) begin
         if (!m_valid) begin
            m_mode  = {shi, slo};
            m_valid = 1;
         end else begin
            if (m_mode == 3) m_ready = (m_bits.size() == NB);
            else             m_ready = 1;
            if (m_mode == 3 && m_bits.size() < NB && !shi) m_bits.push_back(slo);
            if (eofs) begin
               if (m_pcnt == 0) m_py = d & ((1 << W) - 1);
               else             m_px = d & ((1 << W) - 1);
               m_pcnt++;
            end
         end
      end
      @(negedge clk);
   endtask

   task automatic idle(int n, bit shi, bit slo);
      for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, shi, slo);
   endtask

   task automatic do_reset(bit shi, bit slo);
      req = "R2";
      rst_n = 1'b0;
      m_reset();
      idle(3, shi, slo);
      rst_n = 1'b1;
      req = "R1";
      cyc(0, 1, 0, 0, shi, slo);     // mode-latching edge
   endtask

   task automatic serial_word(int y, int x, bit gaps);
      int v;
      v = (y << W) | x;
      for (int i = NB - 1; i >= 0; i--) begin
         if (gaps && (i % 4 == 1)) cyc(0, 1, 0, 0, 1, ~v[i]);   // R8 gap, bit ignored
         cyc(0, 1, 0, 0, 0, v[i]);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL %s watchdog: actual hung expected finish", req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      m_reset();
      @(negedge clk);

      // R3: preset 8, then select toggling ignored (R1) and data writes (R7)
      do_reset(0, 1);
      req = "R3"; idle(3, 0, 1);
      req = "R1"; idle(2, 1, 0); idle(2, 1, 1);
      req = "R7"; cyc(1, 0, 1, 100, 0, 0); cyc(1, 0, 0, 100, 0, 0);

      // R3: preset 64
      do_reset(1, 0);
      req = "R10"; cyc(1, 0, 1, 9, 1, 0);
      req = "R3";  idle(3, 0, 0);
      req = "R7";  cyc(1, 0, 1, 7, 0, 1);

      // R4 R5 R6: write-port load with unqualified writes interleaved
      do_reset(0, 0);
      req = "R10"; cyc(1, 0, 1, 255, 0, 0);   // ready still low
      req = "R4";  idle(2, 0, 0);
      req = "R6";  cyc(0, 0, 1, 11, 0, 0); cyc(1, 1, 1, 12, 0, 0); cyc(1, 0, 0, 13, 0, 0);
      req = "R5";  cyc(1, 0, 1, 300, 0, 0);
      req = "R4";  idle(1, 0, 0);
      req = "R6";  cyc(1, 1, 1, 14, 0, 0);
      req = "R5";  cyc(1, 0, 1, 5, 0, 0);
      idle(1, 0, 0);
      req = "R7";  cyc(1, 0, 1, 77, 0, 0); cyc(1, 0, 1, 400, 0, 0); idle(2, 0, 0);

      // R8 R9: serial load with gaps, writes during load, extra bits after
      do_reset(1, 1);
      req = "R10"; cyc(1, 0, 1, 50, 1, 0);
      req = "R8";  serial_word(300, 37, 1);
      req = "R9";  cyc(0, 1, 0, 0, 0, 1); cyc(0, 1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0, 1);
      req = "R7";  cyc(1, 0, 1, 21, 0, 0); idle(2, 1, 1);

      // R8 R9: back-to-back serial bits, extremes 1 and DEPTH-4
      do_reset(1, 1);
      req = "R8";  serial_word(DEPTH - 4, 1, 0);
      req = "R9";  idle(3, 0, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule